// File: doc/BRIEF.md
# Sync-Point Redundant State Voter

This block checks that two or three redundant processor lanes, all running the same program, still hold the same architectural state. It does not compare them on every clock. A comparison runs only at a synchronization point. Three events open a sync point: an interrupt, an explicit request from software (for example one placed inside a long loop), or any active lane's count of taken branches reaching a programmable value N. Once a sync point opens, the voter waits for each active lane to pulse its arrival strobe. On that pulse it captures the lane's state signature. The window closes when every active lane has arrived or when a programmable timeout runs out, and the captured signatures are then judged.

In triple mode a two-against-one majority identifies a single dissenting lane. That lane is locked out until reset, and voting carries on as a pairwise compare of the two survivors. In dual mode, and in triple mode after a lockout, no majority is possible, so any disagreement raises a sticky fatal fault. A lane that is active but does not arrive before the timeout counts as divergent. Two status fields hold the lane blamed for the most recent failure and the kind of sync point at which that failure was found.

Top module: `sync_voter`

## Requirements
- R1: After reset, `locked` is 000, `fatal` is 0, `fail_lane` is 3 (no lane), `fail_src` is 0 (none), and `cmp_done` and `cmp_ok` are 0.
- R2: A comparison runs only after a sync point opens a window. Arrival strobes seen while no window is open are ignored. Each window yields exactly one `cmp_done` pulse, one cycle long, with `cmp_ok` high in that cycle if no failure was found.
- R3: A high `irq` with no window open starts a window. A failure found in that window records source code 1 in `fail_src`.
- R4: A high `sync_req` starts a window. A failure found there records source code 2.
- R5: Each lane counts its taken-branch pulses. When an active lane's count reaches `branch_n`, that pulse opens a window and the count restarts from zero. Failures found there record source code 3. When `branch_n` is 0, branch counting opens no windows.
- R6: In triple mode with all lanes active, a lane whose signature disagrees with two agreeing lanes gets its bit set in `locked` (bit i for lane i). `fail_lane` is set to that lane and `fatal` stays 0. At most one lane is ever locked.
- R7: In triple mode, if no two active lanes agree, `fatal` is raised and `fail_lane` is 3.
- R8: In dual mode (`triple_mode` = 0) only lanes 0 and 1 take part, and lane 2's strobes and signature have no effect. A mismatch raises `fatal`, and no lane is ever locked.
- R9: An active lane that has not arrived within `tmo_cycles` cycles of the window opening is treated as divergent. In triple mode it is locked out if the other two agree. In dual mode it causes `fatal`.
- R10: A locked lane stays locked until reset. Its strobes, signature and branch count are then ignored, and later windows compare the two remaining lanes, raising `fatal` on any disagreement.
- R11: When several sync sources fire in the same cycle, the recorded source is chosen in priority order: interrupt (1), then explicit request (2), then branch count (3).
- R12: A sync event that fires while a window is already open is dropped and opens no second window.
- R13: `fatal` stays high until reset. `fail_lane` and `fail_src` always describe the most recent failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| triple_mode | input | 1 | 1: three lanes vote; 0: lanes 0 and 1 compare |
| irq | input | 1 | Interrupt taken (sync source) |
| sync_req | input | 1 | Explicit sync request (sync source) |
| lane_br | input | 3 | Per-lane taken-branch pulse |
| lane_arrive | input | 3 | Per-lane arrival strobe with valid signature |
| lane_sig | input | 3*SIG_W | Lane signatures, lane i in bits [i*SIG_W +: SIG_W] |
| branch_n | input | BR_W | Taken branches per automatic sync point; 0 disables |
| tmo_cycles | input | TMO_W | Window length before late lanes count as divergent |
| locked | output | 3 | Lanes excluded from voting |
| fatal | output | 1 | Sticky unrecoverable divergence |
| fail_lane | output | 2 | Lane blamed by the latest failure, 3 if none identifiable |
| fail_src | output | 2 | Sync source of the latest failure: 1 irq, 2 explicit, 3 branch |
| cmp_done | output | 1 | One-cycle pulse when a window has been judged |
| cmp_ok | output | 1 | With cmp_done: signatures agreed |

## Verification
The bench targets the boundary between open and closed windows. Strobes sent before the N-th branch, or before any trigger, must not yield a verdict; a design that latched early arrivals would judge stale signatures. It also covers lanes that never arrive in both modes. A voter that waited forever would hang, and one that ignored absence would pass a dead lane. Degraded triple mode gets its own cases: a design that kept counting the locked lane would either outvote the survivors or miss their mismatch. Simultaneous sources and triggers that fire inside an open window are also exercised, to catch a wrong recorded source or a spurious second verdict.

// File: rtl/svote_pkg.sv
package svote_pkg;

    localparam int LANES = 3;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_IRQ    = 2'd1,
        SRC_EXPL   = 2'd2,
        SRC_BRANCH = 2'd3
    } sync_src_e;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_WAIT = 2'd1,
        WIN_CMP  = 2'd2
    } win_state_e;

    typedef struct packed {
        logic       ok;
        logic       lock;
        logic [1:0] lane;
        logic       fatal;
    } verdict_t;

    localparam logic [1:0] LANE_NONE = 2'd3;

    function automatic sync_src_e pick_src(input logic irq, input logic expl);
        if (irq)       return SRC_IRQ;
        else if (expl) return SRC_EXPL;
        else           return SRC_BRANCH;
    endfunction

endpackage

// File: rtl/svote_branch_ctr.sv
module svote_branch_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br,
    input  logic [CNT_W-1:0] n_lim,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;

    assign lim_m1 = n_lim - CNT_W'(1);
    assign hit    = br && (n_lim != '0) && (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (hit) cnt_q <= '0;
        else if (br)  cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/svote_window.sv
module svote_window
    import svote_pkg::*;
#(
    parameter int SIG_W = 32,
    parameter int TMO_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            active,
    input  logic                        irq,
    input  logic                        expl,
    input  logic                        br_any,
    input  logic [LANES-1:0]            arrive,
    input  logic [LANES-1:0][SIG_W-1:0] sig_in,
    input  logic [TMO_W-1:0]            tmo,
    output logic                        cmp_fire,
    output sync_src_e                   src,
    output logic [LANES-1:0]            arrived,
    output logic [LANES-1:0][SIG_W-1:0] sig_hold
);
    win_state_e       state_q;
    logic [TMO_W-1:0] tmr_q;
    logic [LANES-1:0] take;
    logic [LANES-1:0] arrived_n;
    logic             expire;
    logic             trig;

    assign trig      = irq || expl || br_any;
    assign take      = (state_q == WIN_WAIT) ? (arrive & active & ~arrived) : '0;
    assign arrived_n = arrived | take;
    assign expire    = ({1'b0, tmr_q} + (TMO_W+1)'(1)) >= {1'b0, tmo};
    assign cmp_fire  = (state_q == WIN_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            tmr_q   <= '0;
            arrived <= '0;
            src     <= SRC_NONE;
        end else begin
            case (state_q)
                WIN_IDLE: if (trig) begin
                    state_q <= WIN_WAIT;
                    tmr_q   <= '0;
                    arrived <= '0;
                    src     <= pick_src(irq, expl);
                end
                WIN_WAIT: begin
                    arrived <= arrived_n;
                    if (((arrived_n & active) == active) || expire) state_q <= WIN_CMP;
                    else tmr_q <= tmr_q + TMO_W'(1);
                end
                default: state_q <= WIN_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)          sig_hold[i] <= '0;
            else if (take[i]) sig_hold[i] <= sig_in[i];
        end
    end

    AST_CMP_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_CMP) |-> ($past(state_q) == WIN_WAIT)); // R2
endmodule

// File: rtl/svote_judge.sv
module svote_judge
    import svote_pkg::*;
#(
    parameter int SIG_W = 32
) (
    input  logic [LANES-1:0]            active,
    input  logic [LANES-1:0]            arrived,
    input  logic [LANES-1:0][SIG_W-1:0] sig,
    output verdict_t                    v
);
    logic [LANES-1:0] pres;
    logic e01, e02, e12, pair_eq;

    always_comb begin
        pres    = active & arrived;
        e01     = pres[0] && pres[1] && (sig[0] == sig[1]);
        e02     = pres[0] && pres[2] && (sig[0] == sig[2]);
        e12     = pres[1] && pres[2] && (sig[1] == sig[2]);
        pair_eq = (active == 3'b011) ? e01 :
                  (active == 3'b101) ? e02 :
                  (active == 3'b110) ? e12 : 1'b0;
        v       = '0;
        v.lane  = LANE_NONE;
        if (active == 3'b111) begin
            if (e01 && e12)  v.ok = 1'b1;
            else if (e01)    begin v.lock = 1'b1; v.lane = 2'd2; end
            else if (e02)    begin v.lock = 1'b1; v.lane = 2'd1; end
            else if (e12)    begin v.lock = 1'b1; v.lane = 2'd0; end
            else             v.fatal = 1'b1;
        end else if (pair_eq) begin
            v.ok = 1'b1;
        end else begin
            v.fatal = 1'b1;
        end
        AST_ONE_VERDICT: assert ($countones({v.ok, v.lock, v.fatal}) == 1); // R6
    end
endmodule

// File: rtl/sync_voter.sv
module sync_voter
    import svote_pkg::*;
#(
    parameter int SIG_W = 32,
    parameter int BR_W  = 16,
    parameter int TMO_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   triple_mode,
    input  logic                   irq,
    input  logic                   sync_req,
    input  logic [2:0]             lane_br,
    input  logic [2:0]             lane_arrive,
    input  logic [3*SIG_W-1:0]     lane_sig,
    input  logic [BR_W-1:0]        branch_n,
    input  logic [TMO_W-1:0]       tmo_cycles,
    output logic [2:0]             locked,
    output logic                   fatal,
    output logic [1:0]             fail_lane,
    output logic [1:0]             fail_src,
    output logic                   cmp_done,
    output logic                   cmp_ok
);
    logic [LANES-1:0]            locked_q;
    logic                        fatal_q;
    logic [1:0]                  lane_q;
    sync_src_e                   src_q;
    logic                        done_q, ok_q;
    logic [LANES-1:0]            active, br_hit, arrived;
    logic [LANES-1:0][SIG_W-1:0] sig_in, sig_hold;
    logic                        cmp_fire;
    sync_src_e                   win_src;
    verdict_t                    v;

    assign active = triple_mode ? ~locked_q : 3'b011;
    assign sig_in = lane_sig;

    for (genvar i = 0; i < LANES; i++) begin : g_br
        logic hit;
        svote_branch_ctr #(.CNT_W(BR_W)) u_ctr (
            .clk(clk), .rst(rst), .br(lane_br[i]), .n_lim(branch_n), .hit(hit)
        );
        assign br_hit[i] = hit && active[i];
    end

    svote_window #(.SIG_W(SIG_W), .TMO_W(TMO_W)) u_win (
        .clk(clk), .rst(rst), .active(active), .irq(irq), .expl(sync_req),
        .br_any(|br_hit), .arrive(lane_arrive), .sig_in(sig_in), .tmo(tmo_cycles),
        .cmp_fire(cmp_fire), .src(win_src), .arrived(arrived), .sig_hold(sig_hold)
    );

    svote_judge #(.SIG_W(SIG_W)) u_judge (
        .active(active), .arrived(arrived), .sig(sig_hold), .v(v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= '0;
            fatal_q  <= 1'b0;
            lane_q   <= LANE_NONE;
            src_q    <= SRC_NONE;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
        end else begin
            done_q <= cmp_fire;
            ok_q   <= cmp_fire && v.ok;
            if (cmp_fire && v.lock) begin
                locked_q <= locked_q | (3'b001 << v.lane);
                lane_q   <= v.lane;
                src_q    <= win_src;
            end
            if (cmp_fire && v.fatal) begin
                fatal_q <= 1'b1;
                lane_q  <= LANE_NONE;
                src_q   <= win_src;
            end
        end
    end

    assign locked    = locked_q;
    assign fatal     = fatal_q;
    assign fail_lane = lane_q;
    assign fail_src  = src_q;
    assign cmp_done  = done_q;
    assign cmp_ok    = ok_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(locked_q) & ~locked_q) == 3'b000)); // R10
    AST_SINGLE_LOCK: assert property (@(posedge clk) disable iff (rst)
        ($countones(locked_q) <= 1)); // R6
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fatal_q |=> fatal_q); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R2
    AST_DUAL_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        !$past(triple_mode) |-> (locked_q == $past(locked_q))); // R8
endmodule

// File: tb/sync_voter_tb.sv
module sync_voter_tb;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          triple_mode;
    logic          irq, sync_req;
    logic [2:0]    lane_br, lane_arrive;
    logic [3*SW-1:0] lane_sig;
    logic [15:0]   branch_n;
    logic [11:0]   tmo_cycles;
    logic [2:0]    locked;
    logic          fatal, cmp_done, cmp_ok;
    logic [1:0]    fail_lane, fail_src;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sync_voter #(.SIG_W(SW), .BR_W(16), .TMO_W(12)) u_dut (
        .clk(clk), .rst(rst), .triple_mode(triple_mode), .irq(irq), .sync_req(sync_req),
        .lane_br(lane_br), .lane_arrive(lane_arrive), .lane_sig(lane_sig),
        .branch_n(branch_n), .tmo_cycles(tmo_cycles), .locked(locked), .fatal(fatal),
        .fail_lane(fail_lane), .fail_src(fail_src), .cmp_done(cmp_done), .cmp_ok(cmp_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic tri_m);
        rst = 1'b1; triple_mode = tri_m; irq = 0; sync_req = 0; lane_br = 0;
        lane_arrive = 0; lane_sig = '0; branch_n = 0; tmo_cycles = 12'd20;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done(input int maxc, output bit seen);
        seen = 0;
        for (int k = 0; k < maxc; k++) begin
            @(negedge clk);
            if (cmp_done) begin seen = 1; break; end
        end
    endtask

    task automatic arrive(input logic [2:0] m, input logic [31:0] s0, s1, s2);
        lane_sig = {s2, s1, s0};
        lane_arrive = m;
        @(negedge clk);
        lane_arrive = 0;
    endtask

    // kind: 0 irq, 1 explicit, 3 irq+expl+branch, 4 expl+branch
    task automatic window(input int kind, input logic [2:0] m,
                          input logic [31:0] s0, s1, s2, output bit seen);
        irq      = (kind == 0 || kind == 3);
        sync_req = (kind == 1 || kind == 3 || kind == 4);
        lane_br  = (kind >= 3) ? 3'b001 : 3'b000;
        @(negedge clk);
        irq = 0; sync_req = 0; lane_br = 0;
        arrive(m, s0, s1, s2);
        wait_done(80, seen);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        chk("R1 locked", locked, 0);
        chk("R1 fatal", fatal, 0);
        chk("R1 fail_lane", fail_lane, 3);
        chk("R1 fail_src", fail_src, 0);
        chk("R1 cmp_done/ok", {cmp_done, cmp_ok}, 0);
    endtask

    task automatic t_outside;
        bit seen;
        do_reset(1'b1);
        arrive(3'b111, 32'h1, 32'h2, 32'h3);
        wait_done(15, seen);
        chk("R2 no verdict without sync point", seen, 0);
        chk("R2 fatal untouched", fatal, 0);
    endtask

    task automatic t_irq_match;
        bit seen;
        do_reset(1'b1);
        window(0, 3'b111, 32'hAA, 32'hAA, 32'hAA, seen);
        chk("R3 irq window judged", seen, 1);
        chk("R2 cmp_ok on agreement", cmp_ok, 1);
        @(negedge clk);
        chk("R2 cmp_done one cycle", cmp_done, 0);
        chk("R3 no lock", locked, 0);
    endtask

    task automatic t_lockout;
        bit seen;
        do_reset(1'b1);
        window(0, 3'b111, 32'h55, 32'h99, 32'h55, seen);
        chk("R6 lane1 locked", locked, 3'b010);
        chk("R6 fail_lane", fail_lane, 1);
        chk("R3 fail_src irq", fail_src, 1);
        chk("R6 no fatal", fatal, 0);
        chk("R6 cmp_ok low", cmp_ok, 0);
        // degraded: lane1 garbage ignored, 0 and 2 agree
        window(1, 3'b111, 32'h77, 32'h13, 32'h77, seen);
        chk("R10 degraded agree ok", cmp_ok, 1);
        chk("R10 lock stays", locked, 3'b010);
        chk("R10 no fatal", fatal, 0);
        // lane1 now agrees with lane0, lane2 differs: must be fatal
        window(1, 3'b111, 32'h21, 32'h21, 32'h22, seen);
        chk("R10 degraded mismatch fatal", fatal, 1);
        chk("R10 lock unchanged", locked, 3'b010);
        chk("R13 fail_lane after fatal", fail_lane, 3);
        chk("R4 fail_src explicit", fail_src, 2);
        window(0, 3'b111, 32'h5, 32'h0, 32'h5, seen);
        chk("R13 fatal sticky", fatal, 1);
        chk("R13 src kept after good compare", fail_src, 2);
    endtask

    task automatic t_all_differ;
        bit seen;
        do_reset(1'b1);
        window(1, 3'b111, 32'h1, 32'h2, 32'h3, seen);
        chk("R7 fatal", fatal, 1);
        chk("R7 fail_lane none", fail_lane, 3);
        chk("R7 no lock", locked, 0);
        chk("R4 fail_src explicit", fail_src, 2);
    endtask

    task automatic t_branch;
        bit seen;
        do_reset(1'b1);
        branch_n = 16'd4;
        for (int k = 0; k < 3; k++) begin lane_br = 3'b001; @(negedge clk); end
        lane_br = 0;
        arrive(3'b111, 32'h1, 32'h2, 32'h3);
        wait_done(10, seen);
        chk("R5 no sync before N", seen, 0);
        lane_br = 3'b001; @(negedge clk); lane_br = 0;
        arrive(3'b111, 32'h8, 32'h8, 32'h9);
        wait_done(80, seen);
        chk("R5 sync at N", seen, 1);
        chk("R5 lane2 locked", locked, 3'b100);
        chk("R5 fail_src branch", fail_src, 3);
        // lane2 locked: its branches must not open a window
        for (int k = 0; k < 6; k++) begin lane_br = 3'b100; @(negedge clk); end
        lane_br = 0;
        wait_done(10, seen);
        chk("R10 locked lane branch ignored", seen, 0);
        // N = 0 disables
        do_reset(1'b1);
        for (int k = 0; k < 10; k++) begin lane_br = 3'b111; @(negedge clk); end
        lane_br = 0;
        arrive(3'b111, 32'h1, 32'h2, 32'h3);
        wait_done(10, seen);
        chk("R5 N=0 disables", seen, 0);
    endtask

    task automatic t_dual;
        bit seen;
        do_reset(1'b0);
        window(0, 3'b111, 32'h40, 32'h40, 32'hDEAD, seen);
        chk("R8 lane2 ignored", cmp_ok, 1);
        chk("R8 no fatal", fatal, 0);
        window(0, 3'b011, 32'h40, 32'h41, 32'h0, seen);
        chk("R8 mismatch fatal", fatal, 1);
        chk("R8 no lock", locked, 0);
    endtask

    task automatic t_timeout;
        bit seen;
        do_reset(1'b1);
        window(0, 3'b011, 32'h6, 32'h6, 32'h6, seen);
        chk("R9 window closes on timeout", seen, 1);
        chk("R9 late lane locked", locked, 3'b100);
        chk("R9 fail_lane", fail_lane, 2);
        do_reset(1'b0);
        window(0, 3'b001, 32'h6, 32'h6, 32'h6, seen);
        chk("R9 dual late fatal", fatal, 1);
    endtask

    task automatic t_priority;
        bit seen;
        do_reset(1'b1);
        branch_n = 16'd1;
        window(3, 3'b111, 32'h3, 32'h3, 32'h4, seen);
        chk("R11 irq wins", fail_src, 1);
        do_reset(1'b1);
        branch_n = 16'd1;
        window(4, 3'b111, 32'h3, 32'h4, 32'h3, seen);
        chk("R11 explicit over branch", fail_src, 2);
    endtask

    task automatic t_drop;
        bit seen;
        do_reset(1'b1);
        tmo_cycles = 12'd60;
        irq = 1; @(negedge clk); irq = 0;
        repeat (2) @(negedge clk);
        sync_req = 1; @(negedge clk); sync_req = 0;
        arrive(3'b111, 32'h9, 32'h9, 32'h9);
        wait_done(80, seen);
        chk("R12 first window judged", seen, 1);
        arrive(3'b111, 32'h1, 32'h2, 32'h3);
        wait_done(80, seen);
        chk("R12 dropped trigger opens nothing", seen, 0);
    endtask

    initial begin
        t_reset();
        t_outside();
        t_irq_match();
        t_lockout();
        t_all_differ();
        t_branch();
        t_dual();
        t_timeout();
        t_priority();
        t_drop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule